// File: doc/BRIEF.md
# Framed Serial Word Receiver for a DAC Data Register

This block takes a 24-bit word from a three-wire serial link and places it in a DAC data register. The link has an active-low frame select, a serial clock and a data line. All three pins are sampled by a faster system clock through two-stage synchronisers. Serial clock edges are detected in the system clock domain.

While the frame select is low, each falling serial clock edge shifts one data bit into a shift register, most significant bit first. The register update does not wait for the frame to close: it happens as soon as the 24th falling edge of the frame has been seen. At that moment the word is copied to the output register, and a strobe is raised for one system clock cycle.

If the frame select returns high before the 24th edge, the partial word is discarded and the output keeps its old value. The output side is a valid-only stream: `dac_load_o` acts as the valid, and there is no ready, because the data register always accepts the word and nothing can apply back-pressure. The system clock must run at least four times faster than the serial clock.

Top module: `sdi_word_loader`

## Requirements
- R1: After reset, `dac_word_o` is all zeros and `dac_load_o` is low.
- R2: A frame with 24 falling serial clock edges loads the 24 sampled bits into `dac_word_o`. The first bit sampled becomes bit 23 and the last becomes bit 0.
- R3: The load happens while the frame select is still low. No rising edge of the frame select is needed.
- R4: `dac_load_o` is high for exactly one system clock cycle per completed frame. `dac_word_o` changes only on that cycle.
- R5: A frame that ends after fewer than 24 falling edges (0 to 23) produces no strobe and leaves `dac_word_o` unchanged.
- R6: Falling edges after the 24th in the same frame produce no strobe and leave `dac_word_o` unchanged.
- R7: Each falling edge of the frame select restarts reception at bit zero, so a frame after an aborted one is received in full.
- R8: While the frame select is high, serial clock edges are ignored: no strobe, and no change to `dac_word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Active-low frame select from the serial link |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| sdata_i | input | 1 | Serial data, most significant bit first |
| dac_word_o | output | 24 | DAC data register contents |
| dac_load_o | output | 1 | One-cycle strobe when `dac_word_o` is loaded (stream valid) |

## Verification
The hardest cases to reach are the frame boundaries: an abort after exactly 23 edges, and extra edges after a completed word. In both, the output must show nothing at all. The bench sweeps the abort length over every value from 0 to 23, sending each abort between two full frames with known, differing contents. It also sends frames with up to three extra clock edges. It reads the register and the strobe count before it raises the frame select, so that it can tell an early load from one that happens at frame close.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  localparam int unsigned SDI_WORD_W   = 24;
  localparam int unsigned SDI_SYNC_LEN = 2;
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdi_shifter.sv
module sdi_shifter #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic [WORD_W-1:0] shreg_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic             frame_prev_q;
  logic             sclk_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fall_edge;
  logic             frame_open;
  logic             frame_start;

  assign fall_edge   = sclk_prev_q & ~sclk_s;
  assign frame_open  = ~frame_n_s;
  assign frame_start = frame_prev_q & ~frame_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_prev_q <= 1'b1;
      sclk_prev_q  <= 1'b1;
      cnt_q        <= '0;
      shreg_o      <= '0;
      done_o       <= 1'b0;
    end else begin
      frame_prev_q <= frame_n_s;
      sclk_prev_q  <= sclk_s;
      done_o       <= 1'b0;
      if (!frame_open || frame_start) begin
        cnt_q   <= '0;
        shreg_o <= '0;
      end else if (fall_edge && (cnt_q < CNT_FULL)) begin
        shreg_o <= {shreg_o[WORD_W-2:0], sdata_s};
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) done_o <= 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R6
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_s |=> (cnt_q == '0) && !done_o); // R8
  AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q == CNT_FULL)); // R2
endmodule

// File: rtl/sdi_out_reg.sv
module sdi_out_reg #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= done_i;
      if (done_i) word_o <= word_i;
    end
  end

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o); // R4
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(word_o)); // R5
  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> load_o); // R2
endmodule

// File: rtl/sdi_word_loader.sv
module sdi_word_loader
  import sdi_pkg::*;
#(
  parameter int unsigned WORD_W   = SDI_WORD_W,
  parameter int unsigned SYNC_LEN = SDI_SYNC_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] dac_word_o,
  output logic              dac_load_o
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] shreg;
  logic              done;

  sdi_sync #(.N(3), .STAGES(SYNC_LEN), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({frame_n_i, sclk_i, sdata_i}),
    .q_o   (pins_s)
  );

  sdi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n_s (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .sdata_s   (pins_s[0]),
    .shreg_o   (shreg),
    .done_o    (done)
  );

  sdi_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_i (done),
    .word_i (shreg),
    .word_o (dac_word_o),
    .load_o (dac_load_o)
  );
endmodule

// File: tb/sdi_word_loader_tb_top.sv
module sdi_word_loader_tb_top;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_n = 1'b1;
  logic         sclk = 1'b1;
  logic         sdata = 1'b0;
  logic [W-1:0] dac_word;
  logic         dac_load;

  int checks = 0;
  int errors = 0;
  int loads = 0;
  int run = 0;
  int max_run = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdi_word_loader dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .sclk_i(sclk),
    .sdata_i(sdata), .dac_word_o(dac_word), .dac_load_o(dac_load)
  );

  always @(negedge clk) begin
    if (dac_load) begin
      loads++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial clock half period = 32 ns (4 system clocks)
  task automatic send(input logic [W-1:0] word, input int nbits, input bit use_frame,
                      input string req, input logic [W-1:0] exp_word, input int exp_loads);
    int l0;
    l0 = loads;
    if (use_frame) frame_n = 1'b0;
    #64;
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < W) ? word[W-1-i] : ~sdata;
      #32 sclk = 1'b0;
      #32 sclk = 1'b1;
    end
    #80;
    // sampled with the frame still low (R3)
    chk({req, " word"}, 32'(dac_word), 32'(exp_word));
    chk({req, " loads"}, 32'(loads - l0), 32'(exp_loads));
    frame_n = 1'b1;
    #80;
    chk({req, " word after close"}, 32'(dac_word), 32'(exp_word));
    chk({req, " no late load"}, 32'(loads - l0), 32'(exp_loads));
  endtask

  initial begin
    logic [W-1:0] cur;
    #30;
    @(negedge clk);
    chk("R1 reset word", 32'(dac_word), 32'h0);
    chk("R1 reset load", 32'(dac_load), 32'h0);
    rst_n = 1'b1;
    #40;
    // R2 / R3: walking one over every bit position, then patterns
    for (int b = 0; b < W; b++) send(W'(1) << b, W, 1'b1, "R2 R3 walk", W'(1) << b, 1);
    send(24'hA5C33C, W, 1'b1, "R2 pattern", 24'hA5C33C, 1);
    send(24'hFFFFFF, W, 1'b1, "R2 ones", 24'hFFFFFF, 1);
    cur = 24'h123456;
    send(cur, W, 1'b1, "R2 mixed", cur, 1);
    // R5 / R7: every abort length, then a full frame must arrive intact
    for (int n = 0; n < W; n++) begin
      send(~cur, n, 1'b1, "R5 abort", cur, 0);
      cur = cur ^ W'(24'h5A0F31 + n * 24'h010101);
      send(cur, W, 1'b1, "R7 after abort", cur, 1);
    end
    // R6: extra edges after the 24th
    for (int e = 1; e <= 3; e++) begin
      cur = cur + 24'h111111;
      send(cur, W + e, 1'b1, "R6 extra edges", cur, 1);
    end
    // R8: edges with frame select high
    send(~cur, 30, 1'b0, "R8 frame high", cur, 0);
    send(24'h00F00D, W, 1'b1, "R8 then R7 full", 24'h00F00D, 1);
    // R4: strobe width
    chk("R4 strobe width", 32'(max_run), 32'd1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule